// File: doc/BRIEF.md
# Serial Register-Access Frame Controller

This block sits between a byte receiver and a byte transmitter on a single-master serial bus. It assembles master frames into a small buffer. Each frame holds a sync byte, a control byte, a register address, zero to eight data bytes and a check byte. The controller acts on a frame only after the whole frame has arrived and its CRC-8 matches. It then drives a simple register-file port, writing or reading a burst of consecutive registers. Finally it hands reply bytes, one at a time, to the transmitter over a valid/ready pair.

The control byte selects the direction, the broadcast option, the burst length and the target node. Frames for another node are parsed so that framing stays aligned, but they have no effect. A frame whose CRC fails is dropped without any reply. A one-cycle bus-timeout pulse from the receiver discards any partly received frame, and also any reply in progress, so that the next sync byte starts clean.

Top module: `regframe_ctrl`

## Requirements
- R1: While idle, received bytes other than the sync value 0x55 are ignored. A 0x55 byte starts a frame. The next byte is the control byte: bit 7 = 1 for read and 0 for write, bit 6 = broadcast, bits 5:4 = burst code k giving N = 2^k bytes (1, 2, 4 or 8), bits 3:0 = target node id.
- R2: The check byte is a CRC-8 with polynomial 0x07, initial value 0xFF, processed MSB first, over the control byte, the register address and all data bytes. The sync byte is not included. On a mismatch the frame causes no register access, no transmitted byte and no watchdog pulse.
- R3: A valid write addressed to this node writes its N data bytes, in arrival order, to registers base, base+1, … (modulo 256). It then transmits exactly one status byte equal to `flag_in`.
- R4: A valid read addressed to this node reads registers base … base+N-1 (modulo 256) and transmits their contents in that order, followed by one status byte equal to `flag_in`. `reg_rdata` is taken one cycle after the cycle in which `reg_re` is high.
- R5: A valid write with the broadcast bit set is performed whatever the target id, and transmits nothing.
- R6: A frame whose target id differs from `dev_id` without the broadcast bit causes no register access and no transmitted byte. A valid broadcast read causes no register access and no transmitted byte.
- R7: `wdog_clr` pulses for exactly one cycle after a check byte that matches, on a frame that is addressed to this node or broadcast. It does not pulse on any other frame.
- R8: A `bus_timeout` pulse returns the controller to idle. A partial frame is discarded and any pending reply byte is withdrawn: `tx_valid` is low on the next cycle. A full frame starting with sync afterwards is handled normally.
- R9: While `tx_valid` is high and `tx_ready` is low, `tx_valid` and `tx_byte` hold their values.
- R10: `reg_we` and `reg_re` are never high together, and no reply byte is offered while a register write is being issued.
- R11: After reset, `reg_we`, `reg_re`, `tx_valid` and `wdog_clr` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_valid | input | 1 | One-cycle strobe: a received byte is present |
| rx_byte | input | 8 | Received byte |
| bus_timeout | input | 1 | One-cycle pulse: bus idle too long, discard frame |
| dev_id | input | DEV_AW | Local node id |
| flag_in | input | 8 | Status value returned at the end of each reply |
| reg_we | output | 1 | Register write strobe |
| reg_re | output | 1 | Register read strobe |
| reg_addr | output | REG_AW | Register address for write or read |
| reg_wdata | output | 8 | Register write data |
| reg_rdata | input | 8 | Register read data, valid one cycle after `reg_re` |
| tx_valid | output | 1 | Reply byte offered to the transmitter |
| tx_byte | output | 8 | Reply byte |
| tx_ready | input | 1 | Transmitter accepts the offered byte |
| wdog_clr | output | 1 | One-cycle pulse: communication watchdog clear |

## Verification
The bench builds the controller with its defaults: a 4-bit node id, an 8-bit register address and an 8-entry burst buffer. With these values an eight-byte burst fills the buffer completely. Bases near 0xFF make the register address wrap, and a random target id hits this node about half the time, so both matched and foreign frames occur. A transmitter that randomly refuses bytes keeps the reply stall path busy across all burst lengths.

// File: rtl/fc_pkg.sv
package fc_pkg;

  typedef enum logic [3:0] {
    S_IDLE, S_CTRL, S_REG, S_DATA, S_CHK,
    S_WR_FETCH, S_WR_DO,
    S_RD_REQ, S_RD_WAIT, S_RD_CAP, S_RD_SEND,
    S_ST_LOAD, S_ST_SEND
  } fc_state_e;

  // CRC-8, polynomial 0x07, one byte folded in MSB first
  function automatic logic [7:0] crc8_fold(input logic [7:0] acc, input logic [7:0] din);
    logic [7:0] r;
    r = acc ^ din;
    for (int i = 0; i < 8; i++) begin
      r = r[7] ? ({r[6:0], 1'b0} ^ 8'h07) : {r[6:0], 1'b0};
    end
    return r;
  endfunction

endpackage

// File: rtl/fc_crc8.sv
module fc_crc8 #(
  parameter logic [7:0] SEED = 8'hFF
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       clr,
  input  logic       en,
  input  logic [7:0] din,
  output logic [7:0] crc
);
  import fc_pkg::*;

  always_ff @(posedge clk) begin
    if (rst || clr) crc <= SEED;
    else if (en)    crc <= crc8_fold(crc, din);
  end
endmodule

// File: rtl/fc_byte_buf.sv
module fc_byte_buf #(
  parameter int DEPTH = 8,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [7:0]    wr_data,
  input  logic [AW-1:0] rd_addr,
  output logic [7:0]    rd_data
);
  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
    rd_data <= mem[rd_addr];
  end
endmodule

// File: rtl/regframe_ctrl.sv
module regframe_ctrl #(
  parameter int         DEV_AW    = 4,
  parameter int         REG_AW    = 8,
  parameter int         MAX_BLOG  = 3,
  parameter logic [7:0] SYNC_VAL  = 8'h55
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rx_valid,
  input  logic [7:0]        rx_byte,
  input  logic              bus_timeout,
  input  logic [DEV_AW-1:0] dev_id,
  input  logic [7:0]        flag_in,
  output logic              reg_we,
  output logic              reg_re,
  output logic [REG_AW-1:0] reg_addr,
  output logic [7:0]        reg_wdata,
  input  logic [7:0]        reg_rdata,
  output logic              tx_valid,
  output logic [7:0]        tx_byte,
  input  logic              tx_ready,
  output logic              wdog_clr
);
  import fc_pkg::*;

  localparam int DEPTH = 1 << MAX_BLOG;
  localparam int IDX_W = MAX_BLOG;
  localparam int CNT_W = MAX_BLOG + 1;

  fc_state_e         state;
  logic              is_rd, is_bc, id_hit;
  logic [CNT_W-1:0]  len, idx;
  logic [REG_AW-1:0] base;
  logic [7:0]        crc_val, buf_q;
  logic              rx_ok, last;

  assign rx_ok = rx_valid && !bus_timeout;
  assign last  = (idx == len - CNT_W'(1));

  fc_crc8 u_crc (
    .clk (clk),
    .rst (rst),
    .clr (state == S_IDLE),
    .en  (rx_ok && (state == S_CTRL || state == S_REG || state == S_DATA)),
    .din (rx_byte),
    .crc (crc_val)
  );

  fc_byte_buf #(.DEPTH(DEPTH)) u_buf (
    .clk     (clk),
    .wr_en   (rx_ok && state == S_DATA),
    .wr_addr (idx[IDX_W-1:0]),
    .wr_data (rx_byte),
    .rd_addr (idx[IDX_W-1:0]),
    .rd_data (buf_q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= S_IDLE;
      is_rd     <= 1'b0;
      is_bc     <= 1'b0;
      id_hit    <= 1'b0;
      len       <= '0;
      idx       <= '0;
      base      <= '0;
      reg_we    <= 1'b0;
      reg_re    <= 1'b0;
      reg_addr  <= '0;
      reg_wdata <= '0;
      tx_valid  <= 1'b0;
      tx_byte   <= '0;
      wdog_clr  <= 1'b0;
    end else begin
      reg_we   <= 1'b0;
      reg_re   <= 1'b0;
      wdog_clr <= 1'b0;
      if (bus_timeout) begin
        state    <= S_IDLE;
        tx_valid <= 1'b0;
        idx      <= '0;
      end else begin
        case (state)
          S_IDLE: if (rx_valid && rx_byte == SYNC_VAL) state <= S_CTRL;
          S_CTRL: if (rx_valid) begin
            is_rd  <= rx_byte[7];
            is_bc  <= rx_byte[6];
            len    <= CNT_W'(1) << rx_byte[5:4];
            id_hit <= (rx_byte[DEV_AW-1:0] == dev_id);
            state  <= S_REG;
          end
          S_REG: if (rx_valid) begin
            base  <= rx_byte[REG_AW-1:0];
            idx   <= '0;
            state <= is_rd ? S_CHK : S_DATA;
          end
          S_DATA: if (rx_valid) begin
            idx <= idx + CNT_W'(1);
            if (last) state <= S_CHK;
          end
          S_CHK: if (rx_valid) begin
            idx   <= '0;
            state <= S_IDLE;
            if (rx_byte == crc_val && (is_bc || id_hit)) begin
              wdog_clr <= 1'b1;
              if (!is_rd)      state <= S_WR_FETCH;
              else if (!is_bc) state <= S_RD_REQ;
            end
          end
          S_WR_FETCH: state <= S_WR_DO;
          S_WR_DO: begin
            reg_we    <= 1'b1;
            reg_addr  <= base + REG_AW'(idx);
            reg_wdata <= buf_q;
            idx       <= idx + CNT_W'(1);
            if (last) state <= is_bc ? S_IDLE : S_ST_LOAD;
            else      state <= S_WR_FETCH;
          end
          S_RD_REQ: begin
            reg_re   <= 1'b1;
            reg_addr <= base + REG_AW'(idx);
            state    <= S_RD_WAIT;
          end
          S_RD_WAIT: state <= S_RD_CAP;
          S_RD_CAP: begin
            tx_byte  <= reg_rdata;
            tx_valid <= 1'b1;
            state    <= S_RD_SEND;
          end
          S_RD_SEND: if (tx_ready) begin
            tx_valid <= 1'b0;
            idx      <= idx + CNT_W'(1);
            state    <= last ? S_ST_LOAD : S_RD_REQ;
          end
          S_ST_LOAD: begin
            tx_byte  <= flag_in;
            tx_valid <= 1'b1;
            state    <= S_ST_SEND;
          end
          S_ST_SEND: if (tx_ready) begin
            tx_valid <= 1'b0;
            state    <= S_IDLE;
          end
          default: state <= S_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/regframe_ctrl_chk.sv
module regframe_ctrl_chk #(
  parameter int REG_AW = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              rx_valid,
  input logic              bus_timeout,
  input logic              reg_we,
  input logic              reg_re,
  input logic [REG_AW-1:0] reg_addr,
  input logic              tx_valid,
  input logic [7:0]        tx_byte,
  input logic              tx_ready,
  input logic              wdog_clr
);
  AST_ACCESS_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(reg_we && reg_re)); // R10
  AST_NO_TX_IN_WRITE: assert property (@(posedge clk) disable iff (rst)
    reg_we |-> !tx_valid); // R10
  AST_TX_HOLD: assert property (@(posedge clk) disable iff (rst)
    (tx_valid && !tx_ready && !bus_timeout) |=> (tx_valid && $stable(tx_byte))); // R9
  AST_WDOG_PULSE: assert property (@(posedge clk) disable iff (rst)
    wdog_clr |=> !wdog_clr); // R7
  AST_WDOG_AFTER_BYTE: assert property (@(posedge clk) disable iff (rst)
    $rose(wdog_clr) |-> $past(rx_valid)); // R7
  AST_TIMEOUT_CLR: assert property (@(posedge clk) disable iff (rst)
    bus_timeout |=> (!tx_valid && !reg_we && !reg_re)); // R8
endmodule

bind regframe_ctrl regframe_ctrl_chk #(.REG_AW(REG_AW)) chk_i (
  .clk         (clk),
  .rst         (rst),
  .rx_valid    (rx_valid),
  .bus_timeout (bus_timeout),
  .reg_we      (reg_we),
  .reg_re      (reg_re),
  .reg_addr    (reg_addr),
  .tx_valid    (tx_valid),
  .tx_byte     (tx_byte),
  .tx_ready    (tx_ready),
  .wdog_clr    (wdog_clr)
);

// File: tb/regframe_ctrl_tb_top.sv
module regframe_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam logic [3:0] MY_ID = 4'hA;

  logic clk = 0, rst = 1;
  logic rx_valid = 0, bus_timeout = 0, tx_ready = 0;
  logic [7:0] rx_byte = 0, flag_in = 0, reg_rdata = 0;
  logic [3:0] dev_id = MY_ID;
  logic reg_we, reg_re, tx_valid, wdog_clr;
  logic [7:0] reg_addr, reg_wdata, tx_byte;

  int total = 0, bad = 0;
  bit hold_ready = 0;
  logic [7:0] regs [256];
  logic [7:0] wl_a [64], wl_d [64], txl [64];
  int wcnt = 0, txcnt = 0, wdcnt = 0;

  regframe_ctrl dut_i (
    .clk(clk), .rst(rst), .rx_valid(rx_valid), .rx_byte(rx_byte),
    .bus_timeout(bus_timeout), .dev_id(dev_id), .flag_in(flag_in),
    .reg_we(reg_we), .reg_re(reg_re), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .tx_valid(tx_valid),
    .tx_byte(tx_byte), .tx_ready(tx_ready), .wdog_clr(wdog_clr)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // register file and transmitter models
  always @(posedge clk) begin
    if (reg_re) reg_rdata <= regs[reg_addr];
    if (reg_we) begin
      regs[reg_addr] <= reg_wdata;
      if (wcnt < 64) begin wl_a[wcnt] <= reg_addr; wl_d[wcnt] <= reg_wdata; end
      wcnt <= wcnt + 1;
    end
    if (tx_valid && tx_ready) begin
      if (txcnt < 64) txl[txcnt] <= tx_byte;
      txcnt <= txcnt + 1;
    end
    if (wdog_clr) wdcnt <= wdcnt + 1;
  end

  always @(negedge clk) tx_ready <= hold_ready ? 1'b0 : ($urandom % 4 != 0);

  function automatic logic [7:0] crc_b(input logic [7:0] c, input logic [7:0] d);
    for (int i = 7; i >= 0; i--) begin
      logic fb;
      fb = c[7] ^ d[i];
      c = {c[6:0], 1'b0};
      if (fb) c = c ^ 8'h07;
    end
    return c;
  endfunction

  task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic send_byte(input logic [7:0] b);
    @(negedge clk); rx_valid = 1; rx_byte = b;
    @(negedge clk); rx_valid = 0;
    repeat ($urandom % 3) @(negedge clk);
  endtask

  task automatic pulse_timeout();
    @(negedge clk); bus_timeout = 1;
    @(negedge clk); bus_timeout = 0;
  endtask

  task automatic clear_logs();
    @(negedge clk); wcnt = 0; txcnt = 0; wdcnt = 0;
  endtask

  task automatic run_frame(input bit rd, input bit bc, input logic [1:0] code,
                           input logic [3:0] dst, input logic [7:0] base,
                           input bit bad_crc, input bit junk, input string req);
    int n;
    logic [7:0] dat [8];
    logic [7:0] exp_rd [8];
    logic [7:0] ctl, crc;
    bit good, hit, me;
    int ew, et;
    n = 1 << code;
    ctl = {rd, bc, code, dst};
    flag_in = 8'($urandom);
    crc = crc_b(8'hFF, ctl);
    crc = crc_b(crc, base);
    for (int i = 0; i < 8; i++) begin
      dat[i] = 8'($urandom);
      exp_rd[i] = regs[8'(base + 8'(i))];
      if (!rd && i < n) crc = crc_b(crc, dat[i]);
    end
    clear_logs();
    if (junk) begin send_byte(8'h00); send_byte(8'h13); send_byte(8'hAA); end
    send_byte(8'h55);
    send_byte(ctl);
    send_byte(base);
    if (!rd) for (int i = 0; i < n; i++) send_byte(dat[i]);
    send_byte(bad_crc ? (crc ^ 8'h5A) : crc);
    repeat (300) @(negedge clk);
    good = !bad_crc;
    me   = (dst == MY_ID) && !bc;
    hit  = bc || (dst == MY_ID);
    ew   = (good && hit && !rd) ? n : 0;
    et   = (good && me) ? (rd ? n + 1 : 1) : 0;
    check(wcnt == ew, req, "write count", wcnt, ew);
    check(txcnt == et, req, "reply count", txcnt, et);
    check(wdcnt == int'(good && hit), "R7", "watchdog pulses", wdcnt, int'(good && hit));
    if (wcnt == ew) for (int i = 0; i < ew; i++) begin
      check(wl_a[i] == 8'(base + 8'(i)), req, "write address", wl_a[i], 8'(base + 8'(i)));
      check(wl_d[i] == dat[i], req, "write data", wl_d[i], dat[i]);
    end
    if (txcnt == et && et > 0) begin
      if (rd) for (int i = 0; i < n; i++)
        check(txl[i] == exp_rd[i], "R4", "read reply byte", txl[i], exp_rd[i]);
      check(txl[et-1] == flag_in, req, "status byte", txl[et-1], flag_in);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [7:0] c;
    process::self().srandom(32'd1234);
    for (int i = 0; i < 256; i++) regs[i] = 8'(i) ^ 8'hA5;
    repeat (4) @(negedge clk);
    rst = 0;
    @(negedge clk);
    check(!reg_we && !reg_re && !tx_valid && !wdog_clr, "R11", "reset outputs",
          {reg_we, reg_re, tx_valid, wdog_clr}, 0);

    run_frame(0, 0, 2'd0, MY_ID, 8'h10, 0, 0, "R3");   // single write
    run_frame(0, 0, 2'd3, MY_ID, 8'hFC, 0, 0, "R3");   // 8-byte write, wraps
    run_frame(1, 0, 2'd2, MY_ID, 8'h20, 0, 0, "R4");   // 4-byte read
    run_frame(1, 0, 2'd3, MY_ID, 8'hFA, 0, 0, "R4");   // 8-byte read, wraps
    run_frame(0, 0, 2'd1, MY_ID, 8'h30, 1, 0, "R2");   // bad CRC write
    run_frame(1, 0, 2'd1, MY_ID, 8'h30, 1, 0, "R2");   // bad CRC read
    run_frame(0, 0, 2'd1, 4'h3,  8'h40, 0, 0, "R6");   // foreign write
    run_frame(1, 0, 2'd0, 4'h3,  8'h40, 0, 0, "R6");   // foreign read
    run_frame(0, 1, 2'd2, 4'h5,  8'h50, 0, 0, "R5");   // broadcast write
    run_frame(1, 1, 2'd1, MY_ID, 8'h50, 0, 0, "R6");   // broadcast read
    run_frame(0, 0, 2'd0, MY_ID, 8'h60, 0, 1, "R1");   // junk before sync

    // R8: partial frame discarded by timeout
    send_byte(8'h55); send_byte(8'h30); send_byte(8'h70); send_byte(8'h55);
    pulse_timeout();
    run_frame(0, 0, 2'd1, MY_ID, 8'h74, 0, 0, "R8");

    // R8: timeout withdraws a stalled reply
    hold_ready = 1;
    clear_logs();
    c = crc_b(crc_b(8'hFF, {1'b1, 1'b0, 2'd0, MY_ID}), 8'h11);
    send_byte(8'h55); send_byte({1'b1, 1'b0, 2'd0, MY_ID}); send_byte(8'h11); send_byte(c);
    repeat (20) @(negedge clk);
    check(tx_valid == 1'b1, "R9", "stalled reply held", tx_valid, 1);
    check(tx_byte == regs[8'h11], "R9", "stalled reply byte", tx_byte, regs[8'h11]);
    pulse_timeout();
    check(tx_valid == 1'b0, "R8", "reply withdrawn", tx_valid, 0);
    hold_ready = 0;
    repeat (20) @(negedge clk);
    check(txcnt == 0, "R8", "no bytes after abort", txcnt, 0);

    for (int k = 0; k < 24; k++) begin
      bit rd, bc, bc_crc;
      rd = 1'($urandom); bc = ($urandom % 5 == 0); bc_crc = ($urandom % 5 == 0);
      run_frame(rd, bc, 2'($urandom), ($urandom % 2) ? MY_ID : 4'($urandom),
                8'($urandom), bc_crc, 1'($urandom), rd ? "R4" : "R3");
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule